// File: doc/BRIEF.md
# Microcode Next-Address Sequencer with Fault and Interrupt Traps

This block produces the address of the microinstruction that a microprogrammed control unit executes next, and it holds that address in a register. Each step it evaluates a branch bit. A condition multiplexer chooses that bit from a fixed-true selection, a fixed-false selection or one of the condition-code inputs. A pending fault then overrides the choice and forces the bit low. When the bit is high, the sequencer follows the microinstruction's own next-address field. If that field holds the reserved all-ones value, the sequencer dispatches to the zero-extended opcode instead.

When the branch bit is low, a cascaded priority encoder selects the entry point. Faults take precedence over unmasked interrupts, and interrupts take precedence over the fetch routine. The entry points lie at the bottom 16 microcode words. Interrupts can therefore only enter at instruction boundaries, where the microcode ends with the false selection or with a condition that fails. A fault breaks off the running instruction at the next step.

The register advances only on clock edges where the step enable is high. In a full design the enable is timed after the opcode and condition-code registers have settled. A synchronous reset returns the sequencer to the fetch entry.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads `uaddr` with 0x000, regardless of the other inputs.
- R2: On an edge where `step_en` is low and `rst` is low, `uaddr` keeps its value.
- R3: When the branch bit is 1 and `next_field` is not 0xFFF, the next `uaddr` equals `next_field`.
- R4: When the branch bit is 1 and `next_field` is 0xFFF, the next `uaddr` is `opcode`, zero-extended to 12 bits.
- R5: The condition selection works as follows. `cond_sel` = 0 gives a branch bit of 0. `cond_sel` = 1 gives a branch bit of 1. `cond_sel` = k, for k from 2 to 7, gives `cc[k-2]`.
- R6: When the branch bit is 0 and no fault or unmasked interrupt is pending, the next `uaddr` is the fetch entry 0x000.
- R7: Any asserted `fault_req` bit forces the branch bit to 0 under every selection. The next `uaddr` is then 0x008 + i, where i is the highest asserted fault line. This also holds while `irq_mask` is set.
- R8: Faults win over interrupts. When both are pending, the fault entry is taken.
- R9: When the branch bit is 0, no fault is pending and `irq_mask` is 0, a pending interrupt gives a next `uaddr` of 0x001 + j, where j is the highest asserted interrupt line.
- R10: Interrupt requests have no effect on `uaddr` while the branch bit is 1.
- R11: While `irq_mask` is 1, interrupt requests are ignored, and a step that ends an instruction goes to fetch (0x000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Allows the address register to advance on this edge |
| next_field | input | 12 | Next-address field of the current microinstruction; 0xFFF requests opcode dispatch |
| cond_sel | input | 3 | Condition select: 0 false (end), 1 true (continue), 2..7 pick cc[0..5] |
| cc | input | 6 | Condition-code bits |
| opcode | input | 8 | Instruction-register opcode used for dispatch |
| fault_req | input | 8 | Fault request lines; a higher index has higher priority |
| irq_req | input | 7 | Interrupt request lines; a higher index has higher priority |
| irq_mask | input | 1 | When high, interrupt requests are disregarded |
| uaddr | output | 12 | Registered microinstruction address |

## Verification
The only state in the block is the address register, so every internal error appears on `uaddr` one enabled edge after the inputs that caused it. A wrong priority or mapping shows as an entry address that is off by its line index or lands in the wrong group. A broken condition selection or fault override shows as a jump to the next field where an entry point was expected. A wrong enable or reset path shows as an address that drifts while stalled or that does not return to zero.

// File: rtl/useq_pkg.sv
package useq_pkg;
    // microcode address width and reserved dispatch value
    localparam int ADDR_W     = 12;
    localparam logic [ADDR_W-1:0] DISPATCH_TAG = '1;
    // instruction register opcode width
    localparam int OPC_W      = 8;
    // trap sources
    localparam int N_FAULT    = 8;
    localparam int N_IRQ      = 7;
    // condition selection: 0 = always false, 1 = always true, rest = cc bits
    localparam int COND_SEL_W = 3;
    localparam int N_CC       = (1 << COND_SEL_W) - 2;
    // entry point code width (fetch + interrupts + faults)
    localparam int ENC_W      = $clog2(N_FAULT + N_IRQ + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] uaddr;
    } seq_state_t;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic [COND_SEL_W-1:0] sel,
    input  logic [N_CC-1:0]       cc,
    output logic                  cond_true
);
    always_comb begin
        cond_true = 1'b0;
        if (sel == COND_SEL_W'(1)) begin
            cond_true = 1'b1;
        end
        for (int k = 0; k < N_CC; k++) begin
            if (sel == COND_SEL_W'(k + 2)) begin
                cond_true = cc[k];
            end
        end
    end

    always_comb begin
        if (sel == '0) begin
            assert (!cond_true); // R5
        end
    end
endmodule

// File: rtl/useq_trap_encoder.sv
module useq_trap_encoder
    import useq_pkg::*;
(
    input  logic [N_FAULT-1:0] fault_req,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic               irq_mask,
    output logic               fault_pending,
    output logic [ENC_W-1:0]   entry_code
);
    always_comb begin
        fault_pending = |fault_req;
        entry_code    = '0;
        // ascending scans: the highest asserted line is written last
        for (int j = 0; j < N_IRQ; j++) begin
            if (irq_req[j] && !irq_mask) begin
                entry_code = ENC_W'(j + 1);
            end
        end
        for (int i = 0; i < N_FAULT; i++) begin
            if (fault_req[i]) begin
                entry_code = ENC_W'(N_IRQ + 1 + i);
            end
        end
    end

    always_comb begin
        if (fault_pending) begin
            assert (entry_code > ENC_W'(N_IRQ)); // R8
        end
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic [ADDR_W-1:0]     next_field,
    input  logic [COND_SEL_W-1:0] cond_sel,
    input  logic [N_CC-1:0]       cc,
    input  logic [OPC_W-1:0]      opcode,
    input  logic [N_FAULT-1:0]    fault_req,
    input  logic [N_IRQ-1:0]      irq_req,
    input  logic                  irq_mask,
    output logic [ADDR_W-1:0]     uaddr
);
    seq_state_t state_d, state_q;

    logic             cond_true;
    logic             fault_pending;
    logic [ENC_W-1:0] entry_code;
    logic             branch;

    useq_cond_mux u_cond (
        .sel       (cond_sel),
        .cc        (cc),
        .cond_true (cond_true)
    );

    useq_trap_encoder u_enc (
        .fault_req     (fault_req),
        .irq_req       (irq_req),
        .irq_mask      (irq_mask),
        .fault_pending (fault_pending),
        .entry_code    (entry_code)
    );

    always_comb begin
        state_d = state_q;
        branch  = cond_true && !fault_pending;
        if (rst) begin
            state_d.uaddr = '0;
        end else if (step_en) begin
            if (!branch) begin
                state_d.uaddr = {{(ADDR_W-ENC_W){1'b0}}, entry_code};
            end else if (next_field == DISPATCH_TAG) begin
                state_d.uaddr = {{(ADDR_W-OPC_W){1'b0}}, opcode};
            end else begin
                state_d.uaddr = next_field;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign uaddr = state_q.uaddr;

    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> uaddr == '0); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(uaddr)); // R2
    AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (step_en && |fault_req) |=> uaddr[ADDR_W-1:ENC_W-1] == 1); // R7
    AST_MASKED_END_FETCH: assert property (@(posedge clk) disable iff (rst)
        (step_en && fault_req == '0 && cond_sel == '0 && irq_mask) |=> uaddr == '0); // R11
endmodule

// File: tb/useq_next_addr_test.sv
module useq_next_addr_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        step_en;
    logic [11:0] next_field;
    logic [2:0]  cond_sel;
    logic [5:0]  cc;
    logic [7:0]  opcode;
    logic [7:0]  fault_req;
    logic [6:0]  irq_req;
    logic        irq_mask;
    logic [11:0] uaddr;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #10 clk = ~clk; // 50 MHz

    useq_next_addr uut (
        .clk(clk), .rst(rst), .step_en(step_en), .next_field(next_field),
        .cond_sel(cond_sel), .cc(cc), .opcode(opcode), .fault_req(fault_req),
        .irq_req(irq_req), .irq_mask(irq_mask), .uaddr(uaddr)
    );

    task automatic check(input logic [11:0] exp, input string tag);
        n_tests++;
        if (uaddr !== exp) begin
            n_fail++;
            $display("FAIL %s: uaddr=%h expected=%h", tag, uaddr, exp);
        end
    endtask

    // drive at falling edge, step at rising edge, sample at next falling edge
    task automatic step(input logic [11:0] nf, input logic [2:0] sel,
                        input logic [5:0] c, input logic [7:0] op,
                        input logic [7:0] f, input logic [6:0] ir,
                        input logic m, input logic [11:0] exp, input string tag);
        next_field = nf; cond_sel = sel; cc = c; opcode = op;
        fault_req = f; irq_req = ir; irq_mask = m; step_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1; step_en = 1'b1; next_field = 12'h5A5; cond_sel = 3'd1;
        cc = '0; opcode = 8'hFF; fault_req = 8'hFF; irq_req = '1; irq_mask = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(12'h000, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic t_branch_paths;
        step(12'h123, 3'd1, 6'h00, 8'h00, 8'h00, 7'h00, 1'b0, 12'h123, "R3 continue jump");
        step(12'hFFF, 3'd1, 6'h00, 8'hA5, 8'h00, 7'h00, 1'b0, 12'h0A5, "R4 opcode dispatch");
        step(12'h456, 3'd0, 6'h3F, 8'h00, 8'h00, 7'h00, 1'b0, 12'h000, "R5 R6 end to fetch");
        step(12'h200, 3'd2, 6'h01, 8'h00, 8'h00, 7'h00, 1'b0, 12'h200, "R5 cc0 true");
        step(12'h300, 3'd7, 6'h1F, 8'h00, 8'h00, 7'h00, 1'b0, 12'h000, "R5 cc5 false");
        step(12'h321, 3'd7, 6'h20, 8'h00, 8'h00, 7'h00, 1'b0, 12'h321, "R5 cc5 true");
        step(12'h0FE, 3'd4, 6'h04, 8'h00, 8'h00, 7'h00, 1'b0, 12'h0FE, "R5 cc2 true");
    endtask

    task automatic t_faults;
        step(12'h456, 3'd1, 6'h00, 8'h00, 8'h24, 7'h00, 1'b0, 12'h00D, "R7 fault aborts continue");
        step(12'h111, 3'd0, 6'h00, 8'h00, 8'h01, 7'h7F, 1'b0, 12'h008, "R8 fault over irq");
        step(12'hFFF, 3'd1, 6'h00, 8'h77, 8'h80, 7'h00, 1'b1, 12'h00F, "R7 fault while masked");
    endtask

    task automatic t_interrupts;
        step(12'h222, 3'd0, 6'h00, 8'h00, 8'h00, 7'h0A, 1'b0, 12'h004, "R9 irq highest line");
        step(12'h222, 3'd0, 6'h00, 8'h00, 8'h00, 7'h01, 1'b0, 12'h001, "R9 irq line 0");
        step(12'h222, 3'd3, 6'h00, 8'h00, 8'h00, 7'h40, 1'b0, 12'h007, "R9 irq on failed cond");
        step(12'h0AB, 3'd1, 6'h00, 8'h00, 8'h00, 7'h7F, 1'b0, 12'h0AB, "R10 irq mid-instruction");
        step(12'h0AB, 3'd0, 6'h00, 8'h00, 8'h00, 7'h7F, 1'b1, 12'h000, "R11 masked irq");
    endtask

    task automatic t_stall;
        step(12'h123, 3'd1, 6'h00, 8'h00, 8'h00, 7'h00, 1'b0, 12'h123, "R2 setup");
        step_en = 1'b0; fault_req = 8'hFF; cond_sel = 3'd0; irq_req = '1; next_field = 12'h777;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(12'h123, "R2 stall hold");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(12'h000, "R1 reset mid-run");
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_branch_paths();
        t_faults();
        t_interrupts();
        t_stall();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: uaddr=%h expected=completion", uaddr);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule